// File: doc/BRIEF.md
# Host Byte/Word Data Port with Write and Prefetch FIFOs

This block is the host's data window into a byte-addressed packet memory. Host writes into the window land in a small write FIFO that drains into the memory one byte per cycle. Host reads are served from a separate read FIFO that the block keeps filled by reading ahead from memory, one byte per cycle. The host bus is 16 bits wide. Every access moves a full word, a low byte or a high byte, and the size follows from address bit 0 and an active-low high-byte enable.

Each FIFO works on bytes, so accesses of any size can be mixed in any order, at even or odd addresses, and the byte sequence in memory always matches the host's access order. A word-wide pointer register sets the memory start address for both directions. Loading it waits until the write FIFO is empty, then discards everything prefetched and starts prefetching again from the new address. The write side and the read side each keep their own running address, and both are set by a pointer load. A write therefore becomes visible to reads only after a later pointer load.

Top module: `hdp_fifo`

## Requirements
- R1: After reset both FIFOs are empty, both running addresses are 0, the block writes nothing to memory, `hst_rdy` is high while no access is presented, and the first word read returns memory bytes 0 and 1.
- R2: The access size is decoded as follows: `hst_addr[0]`=0 with `hst_sbhe_n`=0 is a word (2 bytes); `hst_addr[0]`=0 with `hst_sbhe_n`=1 is a low byte; `hst_addr[0]`=1 with `hst_sbhe_n`=0 is a high byte; `hst_addr[0]`=1 with `hst_sbhe_n`=1 moves no byte and has no effect.
- R3: A word write stores `hst_wdata[7:0]` at the write address and `hst_wdata[15:8]` at the next address, at even or odd alignment, and advances the write address by 2.
- R4: A low-byte write stores `hst_wdata[7:0]`, a high-byte write stores `hst_wdata[15:8]`, and either one advances the write address by 1.
- R5: A word read returns the next byte on bits 7:0 and the byte after it on bits 15:8. A low-byte read returns the next byte on bits 7:0 with bits 15:8 at 0. A high-byte read returns the next byte on bits 15:8 with bits 7:0 at 0.
- R6: Any mix of sizes keeps strict byte order in both directions, with no byte lost or repeated.
- R7: The data window decodes at host addresses 8h through Bh. An access to any other address, except a pointer write, moves no data: a read there returns 0 and consumes nothing.
- R8: A word write to address 6h or 7h loads `hst_wdata[AW-1:0]` as the new address for both directions, empties the read FIFO, and makes later reads return bytes from the new address.
- R9: A pointer write is held off (`hst_rdy` low) until the write FIFO is empty. Bytes already queued are written at the old addresses.
- R10: `hst_rdy` goes low for a data read while the read FIFO holds fewer bytes than the access needs, and for a data write while the write FIFO has less free space than the access needs. Neither FIFO ever overflows or underflows.
- R11: On the memory side, at most one byte is written and one byte is read per cycle, and each port's address advances by exactly 1 after every transfer. Read data is expected on `mem_rd_data` one cycle after `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel | input | 1 | Host access strobe |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 4 | Host register address |
| hst_sbhe_n | input | 1 | Active-low high-byte enable |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid while `hst_rdy` is high |
| hst_rdy | output | 1 | The access completes on the clock edge where this is high |
| mem_wr_en | output | 1 | Memory byte write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | 8 | Memory write byte |
| mem_rd_en | output | 1 | Memory byte read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Memory read byte, one cycle after request |

## Verification
Some properties are checked on every cycle. Neither FIFO overflows or underflows. Each memory port's address advances by one per transfer. A pointer load leaves the read FIFO empty and the write address equal to the loaded value. A stalled pointer write lets the write FIFO keep draining at the old address. Other behaviour only shows up in the bench scenarios: the byte lanes and byte order for every access size, odd-alignment words, accesses outside the window that must have no effect, and the stalls that the FIFO limits cause. A reference memory in the bench, built from random mixes of access sizes, compares the full byte stream.

// File: rtl/hdp_pkg.sv
// Shared types and decode helpers for the host data port.
// Assumes the host register map: window at 8h..Bh, pointer at 6h..7h.
package hdp_pkg;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_LO   = 2'd1,
        SZ_HI   = 2'd2,
        SZ_WORD = 2'd3
    } acc_size_e;

    localparam logic [1:0] WIN_TAG = 2'b10;   // hst_addr[3:2] of the data window
    localparam logic [2:0] PTR_TAG = 3'b011;  // hst_addr[3:1] of the pointer register

    // Map address bit 0 and the active-low high-byte enable onto an access size.
    function automatic acc_size_e decode_size(input logic a0, input logic sbhe_n);
        case ({a0, sbhe_n})
            2'b00:   return SZ_WORD;
            2'b01:   return SZ_LO;
            2'b10:   return SZ_HI;
            default: return SZ_NONE;
        endcase
    endfunction

    // Number of bytes that an access of the given size moves.
    function automatic logic [1:0] size_bytes(input acc_size_e s);
        case (s)
            SZ_WORD:      return 2'd2;
            SZ_LO, SZ_HI: return 2'd1;
            default:      return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/hdp_byte_fifo.sv
// Byte-wide FIFO that accepts 0..2 bytes and releases 0..2 bytes per cycle.
// Assumes DEPTH is a power of two of at least 4, and that the caller never
// pushes more than the free space or pops more than the occupancy.
// The head word carries the oldest byte on bits 7:0 and the next one on 15:8.
module hdp_byte_fifo #(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [1:0]                 push_n,
    input  logic [15:0]                push_d,
    input  logic [1:0]                 pop_n,
    output logic [15:0]                head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    store [DEPTH];
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    // Pointer and occupancy update; a flush wins over any transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            wr_idx <= wr_idx + IW'(push_n);
            rd_idx <= rd_idx + IW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // Byte storage, no reset needed since occupancy guards every read.
    always_ff @(posedge clk) begin
        if (!flush && push_n != 2'd0) store[wr_idx] <= push_d[7:0];
        if (!flush && push_n == 2'd2) store[wr_idx + IW'(1)] <= push_d[15:8];
    end

    // Oldest two bytes, presented in arrival order.
    always_comb head = {store[rd_idx + IW'(1)], store[rd_idx]};

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);
    p_push_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> int'(push_n) <= DEPTH - int'(count) + int'(pop_n));
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(count));

endmodule

// File: rtl/hdp_prefetch.sv
// Read-ahead address generator. It requests one byte per cycle while the read
// FIFO plus the byte in flight leave room, and tracks the one-cycle memory
// return. A pointer load restarts it and drops any return still in flight.
module hdp_prefetch #(
    parameter int AW    = 11,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [AW-1:0]              load_addr,
    input  logic [$clog2(DEPTH+1)-1:0] fifo_count,
    output logic                       mem_rd_en,
    output logic [AW-1:0]              mem_rd_addr,
    output logic                       ret_valid
);
    logic pend;

    // Issue only when the byte returning next cycle is sure to fit.
    always_comb mem_rd_en = !load && (int'(fifo_count) + int'(pend) < DEPTH);
    always_comb ret_valid = pend && !load;

    // Running read address and in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_addr <= '0;
            pend        <= 1'b0;
        end else if (load) begin
            mem_rd_addr <= load_addr;
            pend        <= 1'b0;
        end else begin
            pend <= mem_rd_en;
            if (mem_rd_en) mem_rd_addr <= mem_rd_addr + AW'(1);
        end
    end

    p_rd_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_rd_addr == $past(mem_rd_addr) + AW'(1));
    p_load_drops_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ret_valid);

endmodule

// File: rtl/hdp_fifo.sv
// Host data port: 16-bit host window onto a byte-addressed packet memory.
// Writes pass through a byte write FIFO that drains one byte per cycle.
// Reads come from a byte FIFO that a prefetcher keeps filled. A word write
// to the pointer register waits until writes have drained, then retargets
// both directions. Assumes the host holds its access until hst_rdy is high.
module hdp_fifo
    import hdp_pkg::*;
#(
    parameter int AW     = 11,
    parameter int WDEPTH = 4,
    parameter int RDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_sel,
    input  logic          hst_wr,
    input  logic [3:0]    hst_addr,
    input  logic          hst_sbhe_n,
    input  logic [15:0]   hst_wdata,
    output logic [15:0]   hst_rdata,
    output logic          hst_rdy,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [7:0]    mem_wr_data,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data
);
    localparam int WCW = $clog2(WDEPTH + 1);
    localparam int RCW = $clog2(RDEPTH + 1);

    acc_size_e      size;
    logic [1:0]     nbytes;
    logic           is_dw, is_dr, is_pl, acc, load;
    logic [1:0]     wpush_n, wpop_n, rpop_n;
    logic [15:0]    wpush_d, whead, rhead;
    logic [WCW-1:0] wcount;
    logic [RCW-1:0] rcount;
    logic           ret_valid;
    logic           unused_whead_hi;

    // Decode the access type and its size.
    always_comb begin
        size   = decode_size(hst_addr[0], hst_sbhe_n);
        nbytes = size_bytes(size);
        is_dw  = hst_sel && hst_wr  && (hst_addr[3:2] == WIN_TAG);
        is_dr  = hst_sel && !hst_wr && (hst_addr[3:2] == WIN_TAG);
        is_pl  = hst_sel && hst_wr  && (hst_addr[3:1] == PTR_TAG) && size == SZ_WORD;
    end

    // Hold off the host until the selected FIFO can serve the whole access.
    always_comb begin
        if (is_dw)      hst_rdy = (WDEPTH - int'(wcount)) >= int'(nbytes);
        else if (is_dr) hst_rdy = int'(rcount) >= int'(nbytes);
        else if (is_pl) hst_rdy = (wcount == '0);
        else            hst_rdy = 1'b1;
        acc  = hst_sel && hst_rdy;
        load = is_pl && acc;
    end

    // Steer the host lanes into the write FIFO, lowest byte first.
    always_comb begin
        wpush_n = (is_dw && acc) ? nbytes : 2'd0;
        case (size)
            SZ_HI:   wpush_d = {8'h00, hst_wdata[15:8]};
            SZ_LO:   wpush_d = {8'h00, hst_wdata[7:0]};
            default: wpush_d = hst_wdata;
        endcase
    end

    // Steer the read FIFO head onto the host lanes.
    always_comb begin
        rpop_n = (is_dr && acc) ? nbytes : 2'd0;
        if (!is_dr) hst_rdata = 16'h0000;
        else begin
            case (size)
                SZ_WORD: hst_rdata = rhead;
                SZ_LO:   hst_rdata = {8'h00, rhead[7:0]};
                SZ_HI:   hst_rdata = {rhead[7:0], 8'h00};
                default: hst_rdata = 16'h0000;
            endcase
        end
    end

    // Drain the write FIFO one byte per cycle.
    always_comb begin
        mem_wr_en       = (wcount != '0);
        mem_wr_data     = whead[7:0];
        wpop_n          = {1'b0, mem_wr_en};
        unused_whead_hi = ^whead[15:8];
    end

    // Running write address, retargeted by a pointer load.
    always_ff @(posedge clk) begin
        if (!rst_n)         mem_wr_addr <= '0;
        else if (load)      mem_wr_addr <= hst_wdata[AW-1:0];
        else if (mem_wr_en) mem_wr_addr <= mem_wr_addr + AW'(1);
    end

    hdp_byte_fifo #(.DEPTH(WDEPTH)) u_wfifo (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push_n(wpush_n), .push_d(wpush_d), .pop_n(wpop_n),
        .head(whead), .count(wcount)
    );

    hdp_byte_fifo #(.DEPTH(RDEPTH)) u_rfifo (
        .clk(clk), .rst_n(rst_n), .flush(load),
        .push_n({1'b0, ret_valid}), .push_d({8'h00, mem_rd_data}), .pop_n(rpop_n),
        .head(rhead), .count(rcount)
    );

    hdp_prefetch #(.AW(AW), .DEPTH(RDEPTH)) u_pref (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(hst_wdata[AW-1:0]),
        .fifo_count(rcount), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .ret_valid(ret_valid)
    );

    p_wr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> mem_wr_addr == $past(mem_wr_addr) + AW'(1));
    p_load_retargets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rcount == '0) && (mem_wr_addr == $past(hst_wdata[AW-1:0])));
    p_ptr_waits_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pl && !hst_rdy) |=> mem_wr_addr == $past(mem_wr_addr) + AW'(1));
    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_sel |-> hst_rdy);

endmodule

// File: tb/hdp_fifo_tb.sv
`timescale 1ns/1ps
module hdp_fifo_tb;
    localparam int AW = 11;
    localparam int MSZ = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hst_sel = 1'b0, hst_wr = 1'b0, hst_sbhe_n = 1'b1;
    logic [3:0] hst_addr = 4'h0;
    logic [15:0] hst_wdata = 16'h0, hst_rdata;
    logic hst_rdy, mem_wr_en, mem_rd_en;
    logic [AW-1:0] mem_wr_addr, mem_rd_addr;
    logic [7:0] mem_wr_data, mem_rd_q = 8'h00;

    logic [7:0] mem [MSZ];
    logic [7:0] exp_mem [MSZ];
    int checks = 0, errors = 0, wr_pulses = 0;
    int ptr_w = 0, ptr_r = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hdp_fifo #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_sbhe_n(hst_sbhe_n), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_rdy(hst_rdy), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_q)
    );

    // Memory model: one-cycle read latency, byte writes.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_q <= mem[mem_rd_addr];
        if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_pulses <= wr_pulses + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bytes moved for (addr bit 0, high-byte enable) per R2.
    function automatic int nbytes(input logic a0, input logic sbhe_n);
        if (!a0 && !sbhe_n) return 2;
        if (a0 && sbhe_n)   return 0;
        return 1;
    endfunction

    task automatic host_acc(input logic wr, input logic [3:0] addr, input logic sbhe_n,
                            input logic [15:0] wd, output logic [15:0] rd, output int stalls);
        @(negedge clk);
        hst_sel = 1'b1; hst_wr = wr; hst_addr = addr; hst_sbhe_n = sbhe_n; hst_wdata = wd;
        #1;
        stalls = 0;
        while (!hst_rdy && stalls < 1000) begin
            @(negedge clk); #1; stalls++;
        end
        rd = hst_rdata;
        @(posedge clk); #1;
        hst_sel = 1'b0;
    endtask

    task automatic do_load(input int a, output int stalls);
        logic [15:0] rd;
        host_acc(1'b1, 4'h6, 1'b0, 16'(a), rd, stalls);
        ptr_w = a % MSZ; ptr_r = a % MSZ;
    endtask

    task automatic do_write(input logic [3:0] addr, input logic sbhe_n, input logic [15:0] wd,
                            output int stalls);
        logic [15:0] rd;
        int n = nbytes(addr[0], sbhe_n);
        host_acc(1'b1, addr, sbhe_n, wd, rd, stalls);
        if (n == 2) begin
            exp_mem[ptr_w] = wd[7:0]; exp_mem[(ptr_w + 1) % MSZ] = wd[15:8];
        end else if (n == 1) exp_mem[ptr_w] = addr[0] ? wd[15:8] : wd[7:0];
        ptr_w = (ptr_w + n) % MSZ;
    endtask

    task automatic do_read(input logic [3:0] addr, input logic sbhe_n, input string req);
        logic [15:0] rd, ex;
        int st;
        int n = nbytes(addr[0], sbhe_n);
        host_acc(1'b0, addr, sbhe_n, 16'h0, rd, st);
        if (n == 2)       ex = {exp_mem[(ptr_r + 1) % MSZ], exp_mem[ptr_r]};
        else if (n == 0)  ex = 16'h0;
        else if (addr[0]) ex = {exp_mem[ptr_r], 8'h00};
        else              ex = {8'h00, exp_mem[ptr_r]};
        ptr_r = (ptr_r + n) % MSZ;
        chk(rd == ex, req, int'(rd), int'(ex));
    endtask

    task automatic mem_compare(input string req);
        int bad = 0, first = -1;
        repeat (10) @(posedge clk);
        for (int i = 0; i < MSZ; i++)
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, bad, 0);
        if (bad != 0) $display("  first mismatch at %0h", first);
    endtask

    initial begin
        int st, tot, wp;
        logic [15:0] rd;
        void'($urandom(32'd2024));
        for (int i = 0; i < MSZ; i++) begin
            mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
            exp_mem[i] = mem[i];
        end
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        chk(hst_rdy == 1'b1, "R1 idle ready", int'(hst_rdy), 1);
        chk(mem_wr_en == 1'b0, "R1 no write", int'(mem_wr_en), 0);
        chk(mem_rd_addr <= 11'd2, "R1 prefetch from 0", int'(mem_rd_addr), 1);
        do_read(4'h8, 1'b0, "R1 first word from address 0");

        // R2/R5: lanes at odd start
        do_load(5, st);
        do_read(4'h8, 1'b0, "R5 word at odd pointer");
        do_read(4'h8, 1'b1, "R5 low byte lane");
        do_read(4'h9, 1'b0, "R5 high byte lane");
        do_read(4'h9, 1'b1, "R2 no-byte access returns 0");
        do_read(4'hA, 1'b0, "R2 no-byte access consumed nothing");

        // R3: word writes at odd and even alignment
        do_load(12'h101, st);
        do_write(4'h8, 1'b0, 16'hBEEF, st);
        do_write(4'h8, 1'b0, 16'hCAFE, st);
        mem_compare("R3 word writes at odd address");
        // R4: byte lanes on write
        do_load(12'h200, st);
        do_write(4'h8, 1'b1, 16'hAA11, st);
        do_write(4'h9, 1'b0, 16'h22BB, st);
        do_write(4'h9, 1'b1, 16'h3333, st);  // R2: moves nothing
        do_write(4'hA, 1'b0, 16'h5544, st);
        mem_compare("R4 byte lanes written in order");

        // R7: accesses outside the window
        do_load(12'h300, st);
        repeat (6) @(posedge clk);
        wp = wr_pulses;
        host_acc(1'b1, 4'h0, 1'b0, 16'h7777, rd, st);
        host_acc(1'b1, 4'hC, 1'b0, 16'h7777, rd, st);
        host_acc(1'b0, 4'h2, 1'b0, 16'h0, rd, st);
        chk(rd == 16'h0, "R7 read outside window returns 0", int'(rd), 0);
        repeat (6) @(posedge clk);
        chk(wr_pulses == wp, "R7 write outside window stores nothing", wr_pulses, wp);
        do_read(4'hB, 1'b0, "R7 window at Bh, nothing consumed before");

        // R9: pointer load waits for drain; R8 retarget
        do_load(12'h400, st);
        do_write(4'h8, 1'b0, 16'h1234, st);
        do_write(4'hA, 1'b0, 16'h5678, st);
        do_load(12'h402, st);
        chk(st > 0, "R9 pointer load stalled while writes pending", st, 1);
        do_read(4'h8, 1'b0, "R8 read from new pointer sees drained data");
        do_load(12'h400, st);
        do_read(4'h8, 1'b0, "R8 reload flushes stale prefetch");
        mem_compare("R9 queued bytes written at old addresses");

        // R10: stalls on empty read FIFO and full write FIFO
        do_load(12'h500, st);
        host_acc(1'b0, 4'h8, 1'b0, 16'h0, rd, st);
        ptr_r = ptr_r + 2;
        chk(st > 0, "R10 read stalls on empty FIFO", st, 1);
        tot = 0;
        for (int i = 0; i < 6; i++) begin
            do_write(4'h8, 1'b0, 16'(16'h6000 + i), st);
            tot += st;
        end
        chk(tot > 0, "R10 write stalls on full FIFO", tot, 1);
        mem_compare("R11 streamed bytes land at consecutive addresses");

        // R6: random phases of mixed sizes
        for (int ph = 0; ph < 120; ph++) begin
            int base = int'($urandom_range(MSZ - 1));
            int cnt = int'($urandom_range(12, 1));
            bit wr = $urandom_range(1);
            do_load(base, st);
            for (int k = 0; k < cnt; k++) begin
                logic [3:0] a = {2'b10, 1'($urandom_range(1)), 1'($urandom_range(1))};
                logic sb = 1'($urandom_range(1));
                if (wr) do_write(a, sb, 16'($urandom), st);
                else    do_read(a, sb, "R6 random mixed reads");
            end
        end
        do_load(0, st);
        mem_compare("R6 random mixed writes");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule